// File: doc/BRIEF.md
# I2C Target Front End for a 16-bit DAC Register Set

This block sits between a two-wire I2C bus and the digital side of a 16-bit converter. It samples SCL and SDA with the system clock and spots START, repeated START and STOP conditions. It answers its own device address and a shared broadcast address. It turns write frames into updates of three registers: a holding (temporary) code, the active output code and a power setting. The engine pulls SDA low only, which suits an open-drain pad.

Every write frame starts with a control byte. One or more data pairs follow it, each an upper byte and then a lower byte. A pair takes effect only at the falling SCL edge that ends the acknowledge slot after its lower byte. If further pairs follow under the same control byte, each completed pair commits on its own. A read frame returns the holding code's upper byte, then its lower byte, then the control byte of the last commit.

A high-speed master code is refused at the protocol level, and the block raises a flag that stays up until the next STOP.

Top module: `i2c_dac_target`

## Requirements
- R1: After reset the holding code, the output code and the power setting are all zero, `update_o` is low, the high-speed flag is low and SDA is not pulled.
- R2: The block acknowledges only three address bytes: 0x98 (device write), 0x99 (device read) and 0x90 (broadcast write). Every other address byte gets a NACK, including 0x91. After a NACK the block ignores the bus until the next START.
- R3: Every byte of an accepted write frame is acknowledged. Registers change only in response to a completed lower byte, at the falling SCL edge that closes its acknowledge slot. An upper byte on its own changes nothing.
- R4: If control bit 0 is 0 and control bits 5:4 are 01, the pair {upper, lower} is loaded into both the holding code and the output code, and `update_o` pulses. Further pairs in the same frame each load again.
- R5: If control bit 0 is 0 and control bits 5:4 are 00, only the holding code is loaded. The output code keeps its value.
- R6: If control bit 0 is 0 and control bits 5:4 are 11, the holding code is copied to the output code and the data bytes are ignored. If bits 5:4 are 10, no code register changes.
- R7: If control bit 0 is 1, the power setting takes bits 7:5 of the upper byte, whatever bits 5:4 say. The codes are left alone. `powered_down_o` is high whenever the setting is non-zero.
- R8: A read frame sends, MSB first, the holding code's upper byte, then its lower byte, then the last committed control byte. SDA is released after a master NACK.
- R9: A STOP, or a repeated START, in the middle of a frame discards the partial data and commits nothing.
- R10: An address byte whose upper five bits are 00001 (a high-speed master code) is not acknowledged. It sets `hs_mode_o`, which stays high across repeated STARTs and clears on STOP.
- R11: SDA is only ever pulled low. The pull starts only after a falling SCL edge, and it is off whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| temp_code_o | output | 16 | Holding code register |
| dac_code_o | output | 16 | Active output code |
| power_mode_o | output | 3 | Current power setting |
| powered_down_o | output | 1 | High when the power setting is non-zero |
| hs_mode_o | output | 1 | High-speed master code seen since the last STOP |
| update_o | output | 1 | One-cycle pulse when the output code is loaded |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, device address 0x4C (7-bit), broadcast 0x48 and master-code prefix 00001. With the full 8-bit address space this small, every address byte gets its own frame, including each master-code variant and the read addresses. The same default configuration drives a ramp of streamed pairs, every control-field selection, broadcast power and update commands, readback, and both ways of abandoning a frame.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;

  localparam int BYTE_W = 8;
  localparam int DAC_W  = 2 * BYTE_W;
  localparam int PWR_W  = 3;
  localparam int BIT_CW = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} eng_st_e;
  typedef enum logic [1:0] {FR_ADDR, FR_CTRL, FR_MSB, FR_LSB} frame_e;
  typedef enum logic [2:0] {AK_NONE, AK_WRITE, AK_READ, AK_BCAST, AK_HS} addr_kind_e;
  typedef enum logic [2:0] {CA_NONE, CA_LOAD_UPD, CA_LOAD_TMP, CA_UPD, CA_POWER} ctrl_act_e;

  // Sort an address byte into the kind of frame it opens.
  function automatic addr_kind_e classify_addr(input logic [7:0] b,
                                               input logic [6:0] dev,
                                               input logic [6:0] bcast,
                                               input logic [4:0] hs_prefix);
    if (b[7:3] == hs_prefix) return AK_HS;
    if (b[7:1] == dev)       return b[0] ? AK_READ : AK_WRITE;
    if (b[7:1] == bcast && !b[0]) return AK_BCAST;
    return AK_NONE;
  endfunction

  // Bit 0 selects a power command; otherwise bits 5:4 pick the data action.
  function automatic ctrl_act_e decode_ctrl(input logic [7:0] c);
    if (c[0]) return CA_POWER;
    case (c[5:4])
      2'b01:   return CA_LOAD_UPD;
      2'b00:   return CA_LOAD_TMP;
      2'b11:   return CA_UPD;
      default: return CA_NONE;
    endcase
  endfunction

  // Readback order: upper byte, lower byte, control byte.
  function automatic logic [7:0] pick_rd_byte(input logic [1:0] idx,
                                              input logic [DAC_W-1:0] code,
                                              input logic [7:0] ctl);
    case (idx)
      2'd0:    return code[DAC_W-1:BYTE_W];
      2'd1:    return code[BYTE_W-1:0];
      default: return ctl;
    endcase
  endfunction

endpackage

// File: rtl/i2cdac_line_sync.sv
module i2cdac_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ch, sda_ch;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[STAGES-2:0], scl_i};
      sda_ch <= {sda_ch[STAGES-2:0], sda_i};
      scl_p  <= scl_ch[STAGES-1];
      sda_p  <= sda_ch[STAGES-1];
    end
  end

  assign scl_s_o    = scl_ch[STAGES-1];
  assign sda_s_o    = sda_ch[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_p;
  assign scl_fall_o = ~scl_s_o & scl_p;
  assign start_o    = scl_s_o & scl_p & sda_p & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_p & ~sda_p & sda_s_o;

endmodule

// File: rtl/i2cdac_byte_engine.sv
module i2cdac_byte_engine
  import i2cdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h4C,
  parameter logic [6:0] BCAST_ADDR = 7'h48,
  parameter logic [4:0] HS_PREFIX  = 5'b00001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DAC_W-1:0] rd_code_i,
  input  logic [7:0]       rd_ctrl_i,
  output logic             pull_o,
  output logic             hs_o,
  output logic             commit_o,
  output logic [7:0]       ctrl_o,
  output logic [7:0]       msb_o,
  output logic [7:0]       lsb_o
);

  eng_st_e           state_q;
  frame_e            frame_q;
  logic [BIT_CW-1:0] bitcnt_q;
  logic [7:0]        shreg_q, txbyte_q;
  logic              ack_q, rd_q;
  logic [1:0]        rdptr_q;

  // Named events for the checks below.
  addr_kind_e kind_w;
  logic       byte_done_w;
  logic [7:0] next_tx_w;
  logic       addr_ok_w;

  assign kind_w      = classify_addr(shreg_q, DEV_ADDR, BCAST_ADDR, HS_PREFIX);
  assign byte_done_w = (state_q == ST_RX) && scl_fall_i && (bitcnt_q == BIT_CW'(BYTE_W));
  assign next_tx_w   = pick_rd_byte(rdptr_q, rd_code_i, rd_ctrl_i);
  assign addr_ok_w   = (kind_w == AK_WRITE) || (kind_w == AK_READ) || (kind_w == AK_BCAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      frame_q  <= FR_ADDR;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      txbyte_q <= '0;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      rdptr_q  <= '0;
      pull_o   <= 1'b0;
      hs_o     <= 1'b0;
      commit_o <= 1'b0;
      ctrl_o   <= '0;
      msb_o    <= '0;
      lsb_o    <= '0;
    end else begin
      commit_o <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        pull_o  <= 1'b0;
        hs_o    <= 1'b0;
      end else if (start_i) begin
        state_q  <= ST_RX;
        frame_q  <= FR_ADDR;
        bitcnt_q <= '0;
        rdptr_q  <= '0;
        pull_o   <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise_i && bitcnt_q < BIT_CW'(BYTE_W)) begin
              shreg_q  <= {shreg_q[6:0], sda_s_i};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (byte_done_w) begin
              if (frame_q == FR_ADDR) begin
                ack_q  <= addr_ok_w;
                pull_o <= addr_ok_w;
                rd_q   <= (kind_w == AK_READ);
                if (kind_w == AK_HS) hs_o <= 1'b1;
              end else begin
                ack_q  <= 1'b1;
                pull_o <= 1'b1;
              end
              state_q <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              pull_o   <= 1'b0;
              bitcnt_q <= '0;
              if (!ack_q) begin
                state_q <= ST_IDLE;
              end else begin
                case (frame_q)
                  FR_ADDR: begin
                    if (rd_q) begin
                      txbyte_q <= next_tx_w;
                      pull_o   <= ~next_tx_w[7];
                      rdptr_q  <= 2'd1;
                      state_q  <= ST_TX;
                    end else begin
                      frame_q <= FR_CTRL;
                      state_q <= ST_RX;
                    end
                  end
                  FR_CTRL: begin
                    ctrl_o  <= shreg_q;
                    frame_q <= FR_MSB;
                    state_q <= ST_RX;
                  end
                  FR_MSB: begin
                    msb_o   <= shreg_q;
                    frame_q <= FR_LSB;
                    state_q <= ST_RX;
                  end
                  default: begin
                    lsb_o    <= shreg_q;
                    commit_o <= 1'b1;
                    frame_q  <= FR_MSB;
                    state_q  <= ST_RX;
                  end
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bitcnt_q == BIT_CW'(BYTE_W - 1)) begin
                pull_o  <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                txbyte_q <= {txbyte_q[6:0], 1'b0};
                pull_o   <= ~txbyte_q[6];
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              ack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              bitcnt_q <= '0;
              if (ack_q) begin
                txbyte_q <= next_tx_w;
                pull_o   <= ~next_tx_w[7];
                rdptr_q  <= (rdptr_q == 2'd2) ? 2'd0 : rdptr_q + 2'd1;
                state_q  <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_o) |-> !$past(scl_s_i)); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_o); // R11
  AST_HS_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_w && frame_q == FR_ADDR && kind_w == AK_HS) |=> (!pull_o && hs_o)); // R10
  AST_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_w && frame_q == FR_ADDR && addr_ok_w) |=> pull_o); // R2
  AST_COMMIT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(scl_fall_i)); // R3

endmodule

// File: rtl/i2cdac_reg_bank.sv
module i2cdac_reg_bank
  import i2cdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [7:0]       ctrl_i,
  input  logic [7:0]       msb_i,
  input  logic [7:0]       lsb_i,
  output logic [DAC_W-1:0] temp_o,
  output logic [DAC_W-1:0] dac_o,
  output logic [PWR_W-1:0] pwr_o,
  output logic [7:0]       ctrl_o,
  output logic             update_o
);

  ctrl_act_e act_w;
  assign act_w = decode_ctrl(ctrl_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_o   <= '0;
      dac_o    <= '0;
      pwr_o    <= '0;
      ctrl_o   <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (commit_i) begin
        ctrl_o <= ctrl_i;
        case (act_w)
          CA_POWER: pwr_o <= msb_i[7:8-PWR_W];
          CA_LOAD_UPD: begin
            temp_o   <= {msb_i, lsb_i};
            dac_o    <= {msb_i, lsb_i};
            update_o <= 1'b1;
          end
          CA_LOAD_TMP: temp_o <= {msb_i, lsb_i};
          CA_UPD: begin
            dac_o    <= temp_o;
            update_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_DAC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(dac_o)); // R3
  AST_TEMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(temp_o)); // R5
  AST_PWR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(pwr_o)); // R7
  AST_UPDATE_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> $past(commit_i)); // R4

endmodule

// File: rtl/i2c_dac_target.sv
module i2c_dac_target
  import i2cdac_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter logic [6:0] BCAST_ADDR  = 7'h48,
  parameter logic [4:0] HS_PREFIX   = 5'b00001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [DAC_W-1:0] temp_code_o,
  output logic [DAC_W-1:0] dac_code_o,
  output logic [PWR_W-1:0] power_mode_o,
  output logic             powered_down_o,
  output logic             hs_mode_o,
  output logic             update_o
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic commit;
  logic [7:0] ctrl_b, msb_b, lsb_b, last_ctrl;

  i2cdac_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2cdac_byte_engine #(.DEV_ADDR(DEV_ADDR), .BCAST_ADDR(BCAST_ADDR), .HS_PREFIX(HS_PREFIX)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .rd_code_i(temp_code_o), .rd_ctrl_i(last_ctrl),
    .pull_o(sda_pull_o), .hs_o(hs_mode_o), .commit_o(commit),
    .ctrl_o(ctrl_b), .msb_o(msb_b), .lsb_o(lsb_b)
  );

  i2cdac_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(commit),
    .ctrl_i(ctrl_b), .msb_i(msb_b), .lsb_i(lsb_b),
    .temp_o(temp_code_o), .dac_o(dac_code_o), .pwr_o(power_mode_o),
    .ctrl_o(last_ctrl), .update_o(update_o)
  );

  assign powered_down_o = |power_mode_o;

endmodule

// File: tb/test_i2c_dac_target.sv
`timescale 1ns/1ps
module test_i2c_dac_target;

  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull, powered_down, hs_mode, upd;
  logic [15:0] temp_code, dac_code;
  logic [2:0]  pwr;
  wire sda_bus = m_sda & ~sda_pull;

  int checks = 0;
  int errs = 0;
  int exp_temp = 0, exp_dac = 0, exp_pwr = 0, exp_ctrl = 0;

  always #4 clk = ~clk;

  i2c_dac_target i_i2c_dac_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .temp_code_o(temp_code), .dac_code_o(dac_code),
    .power_mode_o(pwr), .powered_down_o(powered_down), .hs_mode_o(hs_mode),
    .update_o(upd)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q(Q);
    m_scl = 1'b1; wait_q(Q);
    m_sda = 1'b0; wait_q(Q);
    m_scl = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q(Q);
    m_scl = 1'b1; wait_q(Q);
    m_sda = 1'b1; wait_q(3*Q);
  endtask

  task automatic send_bit(input logic v);
    m_sda = v; wait_q(Q);
    m_scl = 1'b1; wait_q(2*Q);
    m_scl = 1'b0; wait_q(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wait_q(Q);
    m_scl = 1'b1; wait_q(Q);
    acked = ~sda_bus; wait_q(Q);
    m_scl = 1'b0; wait_q(Q);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic master_ack);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_q(Q);
      m_scl = 1'b1; wait_q(Q);
      b = {b[6:0], sda_bus}; wait_q(Q);
      m_scl = 1'b0; wait_q(Q);
    end
    send_bit(~master_ack);
  endtask

  // Expected register effects, restated from the requirements.
  task automatic model_apply(input int c, input int m, input int l);
    int sel;
    sel = (c / 16) % 4;
    exp_ctrl = c;
    if (c % 2 == 1) exp_pwr = m / 32;
    else if (sel == 1) begin exp_temp = m * 256 + l; exp_dac = exp_temp; end
    else if (sel == 0) exp_temp = m * 256 + l;
    else if (sel == 3) exp_dac = exp_temp;
  endtask

  task automatic check_regs(input string req);
    check_eq(req, "dac_code", int'(dac_code), exp_dac);
    check_eq(req, "temp_code", int'(temp_code), exp_temp);
    check_eq(req, "power_mode", int'(pwr), exp_pwr);
    check_eq(req, "powered_down", int'(powered_down), int'(exp_pwr != 0));
  endtask

  task automatic do_write(input string req, input logic [7:0] a, input logic [7:0] c,
                          input logic [7:0] m, input logic [7:0] l);
    logic k;
    bus_start();
    write_byte(a, k); check_eq("R2", "address ack", int'(k), 1);
    write_byte(c, k); check_eq("R3", "control ack", int'(k), 1);
    write_byte(m, k); check_eq("R3", "upper ack", int'(k), 1);
    write_byte(l, k); check_eq("R3", "lower ack", int'(k), 1);
    bus_stop();
    model_apply(int'(c), int'(m), int'(l));
    check_regs(req);
  endtask

  task automatic do_read(input string req);
    logic k;
    logic [7:0] b;
    bus_start();
    write_byte(8'h99, k); check_eq("R2", "read address ack", int'(k), 1);
    read_byte(b, 1'b1); check_eq(req, "readback upper", int'(b), exp_temp / 256);
    read_byte(b, 1'b1); check_eq(req, "readback lower", int'(b), exp_temp % 256);
    read_byte(b, 1'b0); check_eq(req, "readback control", int'(b), exp_ctrl);
    check_eq("R11", "released after master nack", int'(sda_pull), 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic k;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_q(4);
    // R1 reset state
    check_regs("R1");
    check_eq("R1", "sda pull", int'(sda_pull), 0);
    check_eq("R1", "hs flag", int'(hs_mode), 0);
    check_eq("R1", "update", int'(upd), 0);

    // R2 / R10: sweep of every address byte
    for (int a = 0; a < 256; a++) begin
      int want;
      want = (a == 8'h98 || a == 8'h99 || a == 8'h90) ? 1 : 0;
      bus_start();
      write_byte(8'(a), k);
      check_eq("R2", $sformatf("ack of address 0x%02h", a), int'(k), want);
      if (a / 8 == 1) begin
        wait_q(4);
        check_eq("R10", "hs flag after master code", int'(hs_mode), 1);
      end
      if (a == 8'h99) begin
        read_byte(b, 1'b1); check_eq("R8", "sweep readback upper", int'(b), 0);
        read_byte(b, 1'b1); check_eq("R8", "sweep readback lower", int'(b), 0);
        read_byte(b, 1'b0); check_eq("R8", "sweep readback control", int'(b), 0);
      end
      bus_stop();
      if (a / 8 == 1) check_eq("R10", "hs flag after stop", int'(hs_mode), 0);
    end
    check_regs("R1");

    // R3 / R4: streamed ramp under one control byte
    bus_start();
    write_byte(8'h98, k); check_eq("R2", "address ack", int'(k), 1);
    write_byte(8'h10, k); check_eq("R3", "control ack", int'(k), 1);
    for (int n = 0; n < 8; n++) begin
      write_byte(8'(n), k); check_eq("R3", "stream upper ack", int'(k), 1);
      wait_q(6);
      check_eq("R3", "output held after upper byte", int'(dac_code), exp_dac);
      write_byte(8'((n * 37) % 256), k); check_eq("R3", "stream lower ack", int'(k), 1);
      wait_q(6);
      model_apply(8'h10, n, (n * 37) % 256);
      check_eq("R4", "streamed output", int'(dac_code), exp_dac);
      check_eq("R4", "streamed holding", int'(temp_code), exp_temp);
    end
    bus_stop();

    do_write("R4", 8'h98, 8'h10, 8'hA5, 8'hC3);
    do_write("R4", 8'h98, 8'h10, 8'hFF, 8'hFF);
    do_write("R4", 8'h98, 8'h10, 8'h12, 8'h34);
    do_read("R8");

    // R5 holding only, R6 broadcast copy and no-op selection
    do_write("R5", 8'h98, 8'h00, 8'hBE, 8'hEF);
    do_write("R6", 8'h90, 8'h30, 8'h55, 8'h55);
    do_write("R6", 8'h98, 8'h20, 8'h77, 8'h11);
    do_read("R8");

    // R7 power commands, device and broadcast, and precedence of bit 0
    do_write("R7", 8'h98, 8'h11, 8'h60, 8'h00);
    do_write("R7", 8'h90, 8'h35, 8'hC0, 8'h00);
    do_write("R5", 8'h98, 8'h00, 8'h0F, 8'h0F);
    do_write("R7", 8'h98, 8'h31, 8'h20, 8'h00);
    do_write("R7", 8'h98, 8'h11, 8'h00, 8'h00);

    // R9 abandoned frames
    bus_start();
    write_byte(8'h98, k); write_byte(8'h10, k); write_byte(8'h77, k);
    bus_stop();
    check_regs("R9");
    bus_start();
    write_byte(8'h98, k); write_byte(8'h10, k); write_byte(8'h66, k);
    bus_start();
    write_byte(8'h98, k); check_eq("R9", "ack after repeated start", int'(k), 1);
    bus_stop();
    check_regs("R9");

    // R2 a refused address leaves the frame ignored
    bus_start();
    write_byte(8'h9A, k); check_eq("R2", "foreign address nack", int'(k), 0);
    write_byte(8'h10, k); check_eq("R2", "ignored control nack", int'(k), 0);
    write_byte(8'hAA, k); check_eq("R2", "ignored upper nack", int'(k), 0);
    write_byte(8'hBB, k); check_eq("R2", "ignored lower nack", int'(k), 0);
    bus_stop();
    check_regs("R2");

    // R10 master code, repeated start, write while flag is up
    bus_start();
    write_byte(8'h08, k); check_eq("R10", "master code nack", int'(k), 0);
    wait_q(4);
    check_eq("R10", "hs flag set", int'(hs_mode), 1);
    bus_start();
    write_byte(8'h98, k); check_eq("R10", "address after master code", int'(k), 1);
    write_byte(8'h10, k); write_byte(8'h00, k); write_byte(8'h2A, k);
    wait_q(6);
    model_apply(8'h10, 8'h00, 8'h2A);
    check_eq("R10", "hs flag across repeated start", int'(hs_mode), 1);
    check_eq("R4", "output written in high-speed frame", int'(dac_code), exp_dac);
    bus_stop();
    check_eq("R10", "hs flag cleared", int'(hs_mode), 0);
    check_eq("R11", "idle release", int'(sda_pull), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule